// File: doc/BRIEF.md
# Split-Section Divide-by-Sixteen Counter

The block holds two counters that share nothing but their reset. A one-bit section toggles its output on every falling edge of its own count input, so it divides that input by two. A three-bit section steps up by one on every falling edge of a second count input, so it divides that input by two, four and eight at its three output bits. Both count inputs are asynchronous to the system clock. The block samples each one through a synchronizer and turns a high-to-low change of the synchronized level into a count event. This gives ripple-counter behaviour inside a single-clock design.

Clearing needs two reset inputs to be high at the same time. While both are high, every register clears at once, without waiting for a clock edge. Reset release is synchronized, so the counters come out of reset on a known clock edge. A four-bit divide-by-sixteen counter can be built in either of two ways. The first is to wire the one-bit output back to the second count input outside the block. The second is to set a parameter that chains the sections internally: the upper section then steps on the same clock edge where the one-bit output falls.

Top module: `dual_div_counter`

## Requirements
- R1: `q_lo` inverts exactly once for each recognised high-to-low change of `cnt_lo_in`. A low-to-high change of `cnt_lo_in` leaves it unchanged.
- R2: With `CHAIN_MODE` external (the default), `q_hi` increases by one for each recognised high-to-low change of `cnt_hi_in`. `q_hi[0]` is the least significant bit.
- R3: `q_hi` wraps from its maximum value (7 for the default width of 3) to 0 on the next count event.
- R4: With `CHAIN_MODE` external, changes of `cnt_lo_in` have no effect on `q_hi`, and changes of `cnt_hi_in` have no effect on `q_lo`.
- R5: Clearing happens only when `rst_a` and `rst_b` are both 1. Either one at 1 alone leaves counting unchanged.
- R6: When `rst_a` and `rst_b` are both 1, `q_lo` and `q_hi` go to 0 immediately, without a clock edge.
- R7: While both reset inputs are 1, the outputs stay at 0 whatever the count inputs do.
- R8: After reset release (one of the reset inputs falls to 0), the outputs stay 0 through the first two rising clock edges. A count input is first sampled at the third rising edge, so a level change during the first two edges after release produces no count.
- R9: A falling edge of a count input that arrives between rising edges k-1 and k changes the outputs at rising edge k+2 and not before.
- R10: With `CHAIN_MODE` internal, `q_hi` steps at the same rising edge where `q_lo` goes from 1 to 0, and `cnt_hi_in` is ignored. `{q_hi, q_lo}` then counts falling edges of `cnt_lo_in` modulo 16.
- R11: With `CHAIN_MODE` external and `q_lo` wired to `cnt_hi_in`, `{q_hi, q_lo}` settles to the number of falling edges of `cnt_lo_in` modulo 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the count inputs |
| rst_a | input | 1 | First reset input. Clears only together with rst_b |
| rst_b | input | 1 | Second reset input. Clears only together with rst_a |
| cnt_lo_in | input | 1 | Count input of the one-bit section, asynchronous |
| cnt_hi_in | input | 1 | Count input of the upper section, asynchronous. Ignored in internal chain mode |
| q_lo | output | 1 | Output of the one-bit section (divide by two) |
| q_hi | output | HI_W | Upper section count, bit 0 least significant |

## Verification
The hardest cases to reach are those that depend on where a reset or an input change falls relative to the clock. One is a reset that clears the outputs between two edges. The other is a count input that falls within the first two edges after reset release. The bench drives reset on the falling clock edge and samples the outputs shortly after, before any rising edge. It also holds a count input high through reset and drops it one cycle after release, so it can check that this change is not counted. A behavioural model runs alongside two instances, one chained externally through the bench and one chained internally. It is compared every cycle, and pulses of varied width take both sections through their wrap points.

// File: rtl/dual_div_pkg.sv
package dual_div_pkg;

   // How the upper section obtains its count events.
   typedef enum logic {
      CHAIN_EXTERNAL = 1'b0,   // upper section follows its own count input
      CHAIN_INTERNAL = 1'b1    // upper section follows the fall of the one-bit output
   } chain_mode_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/ddc_reset_gate.sv
// Two-input AND reset: asynchronous assertion, release aligned to clk.
module ddc_reset_gate #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_a,
   input  logic rst_b,
   output logic hold_n
);

   logic              clear;
   logic [STAGES-1:0] pipe;

   assign clear = rst_a & rst_b;

   always_ff @(posedge clk or posedge clear) begin
      if (clear) begin
         pipe <= '0;
      end else begin
         pipe <= {pipe[STAGES-2:0], 1'b1};
      end
   end

   assign hold_n = pipe[STAGES-1];

endmodule

// File: rtl/ddc_fall_detect.sv
// Synchronizes an asynchronous count input and flags its high-to-low change.
module ddc_fall_detect #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);

   logic [STAGES-1:0] sync;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync <= '0;
         last <= 1'b0;
      end else begin
         sync <= {sync[STAGES-2:0], din};
         last <= sync[STAGES-1];
      end
   end

   assign fall = last & ~sync[STAGES-1];

endmodule

// File: rtl/ddc_count_stage.sv
// Binary up counter of parameter width; width 1 degenerates to a toggle.
module ddc_count_stage #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] value
);

   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (step) begin
         value <= value + ONE;
      end
   end

endmodule

// File: rtl/dual_div_counter.sv
module dual_div_counter
   import dual_div_pkg::*;
#(
   parameter int unsigned HI_W           = 3,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned RELEASE_STAGES = 2,
   parameter chain_mode_e CHAIN_MODE     = CHAIN_EXTERNAL
) (
   input  logic            clk,
   input  logic            rst_a,
   input  logic            rst_b,
   input  logic            cnt_lo_in,
   input  logic            cnt_hi_in,
   output logic            q_lo,
   output logic [HI_W-1:0] q_hi
);

   // Elaboration-time parameter checks
   if (HI_W < 1) begin : g_bad_width
      $error("dual_div_counter: HI_W must be at least 1");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("dual_div_counter: SYNC_STAGES below minimum");
   end
   if (RELEASE_STAGES < 2) begin : g_bad_release
      $error("dual_div_counter: RELEASE_STAGES must be at least 2");
   end

   logic hold_n;
   logic lo_fall;
   logic hi_step;

   ddc_reset_gate #(
      .STAGES (RELEASE_STAGES)
   ) u_rst (
      .clk    (clk),
      .rst_a  (rst_a),
      .rst_b  (rst_b),
      .hold_n (hold_n)
   );

   ddc_fall_detect #(
      .STAGES (SYNC_STAGES)
   ) u_lo_edge (
      .clk   (clk),
      .rst_n (hold_n),
      .din   (cnt_lo_in),
      .fall  (lo_fall)
   );

   ddc_count_stage #(
      .W (1)
   ) u_lo_cnt (
      .clk   (clk),
      .rst_n (hold_n),
      .step  (lo_fall),
      .value (q_lo)
   );

   if (CHAIN_MODE == CHAIN_INTERNAL) begin : g_chain_int
      // q_lo falls on exactly the edge where it is 1 and steps
      logic unused_hi_in;
      assign unused_hi_in = cnt_hi_in;
      assign hi_step      = lo_fall & q_lo;
   end else begin : g_chain_ext
      ddc_fall_detect #(
         .STAGES (SYNC_STAGES)
      ) u_hi_edge (
         .clk   (clk),
         .rst_n (hold_n),
         .din   (cnt_hi_in),
         .fall  (hi_step)
      );
   end

   ddc_count_stage #(
      .W (HI_W)
   ) u_hi_cnt (
      .clk   (clk),
      .rst_n (hold_n),
      .step  (hi_step),
      .value (q_hi)
   );

endmodule

// File: rtl/dual_div_counter_chk.sv
module dual_div_counter_chk
   import dual_div_pkg::*;
#(
   parameter int unsigned HI_W       = 3,
   parameter chain_mode_e CHAIN_MODE = CHAIN_EXTERNAL
) (
   input logic            clk,
   input logic            rst_a,
   input logic            rst_b,
   input logic            hold_n,
   input logic            lo_fall,
   input logic            hi_step,
   input logic            q_lo,
   input logic [HI_W-1:0] q_hi
);

   // R6: with both resets high the outputs are zero
   assert_clear_in_reset_R6: assert property (@(negedge clk)
      (rst_a && rst_b) |-> (q_lo == 1'b0 && q_hi == '0));

   // R8: outputs held at zero until the release pipeline completes
   assert_hold_clear_R8: assert property (@(posedge clk)
      !hold_n |-> (q_lo == 1'b0 && q_hi == '0));

   // R1: q_lo changes only after a detected fall of its input
   assert_lo_needs_edge_R1: assert property (@(posedge clk) disable iff (rst_a && rst_b)
      (hold_n && $past(hold_n) && q_lo != $past(q_lo)) |-> $past(lo_fall));

   // R3: the upper section only ever steps by one, wrapping at the top
   assert_hi_step_one_R3: assert property (@(posedge clk) disable iff (rst_a && rst_b)
      (hold_n && $past(hold_n) && q_hi != $past(q_hi))
         |-> (q_hi == HI_W'($past(q_hi) + 1'b1)));

   if (CHAIN_MODE == CHAIN_INTERNAL) begin : g_chain_chk
      // R10: upper section moves on the edge where q_lo falls
      assert_chain_same_edge_R10: assert property (@(posedge clk) disable iff (rst_a && rst_b)
         (hold_n && $past(hold_n) && q_hi != $past(q_hi)) |-> ($past(q_lo) && !q_lo));
   end else begin : g_ext_chk
      // R2: upper section moves only after a detected fall of its input
      assert_hi_needs_edge_R2: assert property (@(posedge clk) disable iff (rst_a && rst_b)
         (hold_n && $past(hold_n) && q_hi != $past(q_hi)) |-> $past(hi_step));
   end

endmodule

bind dual_div_counter dual_div_counter_chk #(
   .HI_W       (HI_W),
   .CHAIN_MODE (CHAIN_MODE)
) u_chk (
   .clk     (clk),
   .rst_a   (rst_a),
   .rst_b   (rst_b),
   .hold_n  (hold_n),
   .lo_fall (lo_fall),
   .hi_step (hi_step),
   .q_lo    (q_lo),
   .q_hi    (q_hi)
);

// File: tb/dual_div_counter_test.sv
module dual_div_counter_test;
   import dual_div_pkg::*;

   logic       clk = 1'b0;
   logic       rst_a, rst_b, lo_in, hi_drv, ext_chain;
   logic       hi_to_uut;
   logic       q_lo_a, q_lo_c;
   logic [2:0] q_hi_a, q_hi_c;

   int    checks = 0;
   int    bad    = 0;
   bit    done   = 1'b0;
   string phase  = "R7";

   // model state: index 0 = external-mode instance, 1 = internal-chain instance
   int m_lo  [2];
   int m_hi  [2];
   int rel   [2];
   int lo_h  [2][3];   // [0]=oldest sample, [2]=newest
   int hi_h  [2][3];

   always #10 clk = ~clk;   // 50 MHz

   assign hi_to_uut = ext_chain ? q_lo_a : hi_drv;

   dual_div_counter uut (
      .clk (clk), .rst_a (rst_a), .rst_b (rst_b),
      .cnt_lo_in (lo_in), .cnt_hi_in (hi_to_uut),
      .q_lo (q_lo_a), .q_hi (q_hi_a)
   );

   dual_div_counter #(.CHAIN_MODE (CHAIN_INTERNAL)) uut_chain (
      .clk (clk), .rst_a (rst_a), .rst_b (rst_b),
      .cnt_lo_in (lo_in), .cnt_hi_in (hi_drv),
      .q_lo (q_lo_c), .q_hi (q_hi_c)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      for (int m = 0; m < 2; m++) begin
         m_lo[m] = 0; m_hi[m] = 0; rel[m] = 0;
         for (int i = 0; i < 3; i++) begin
            lo_h[m][i] = 0; hi_h[m][i] = 0;
         end
      end
   endtask

   task automatic push(input int m, input int lv, input int hv);
      for (int i = 0; i < 2; i++) begin
         lo_h[m][i] = lo_h[m][i+1];
         hi_h[m][i] = hi_h[m][i+1];
      end
      lo_h[m][2] = lv;
      hi_h[m][2] = hv;
   endtask

   // behavioural reference, evaluated at every rising edge
   always @(posedge clk) begin
      for (int m = 0; m < 2; m++) begin
         if (rst_a && rst_b) begin
            model_clear();
         end else if (rel[m] < 2) begin
            rel[m]++;
            push(m, 0, 0);
         end else begin
            int  old_lo;
            int  hi_sample;
            bit  lo_ev, hi_ev;
            old_lo = m_lo[m];
            lo_ev  = (lo_h[m][0] == 1) && (lo_h[m][1] == 0);
            if (m == 1) hi_ev = lo_ev && (old_lo == 1);
            else        hi_ev = (hi_h[m][0] == 1) && (hi_h[m][1] == 0);
            if (lo_ev) m_lo[m] = 1 - m_lo[m];
            if (hi_ev) m_hi[m] = (m_hi[m] + 1) % 8;
            hi_sample = (m == 0 && ext_chain) ? old_lo : int'(hi_drv);
            push(m, int'(lo_in), hi_sample);
         end
      end
   end

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      #2;
      if (!done) begin
         check(phase, {q_hi_a, q_lo_a}, m_hi[0] * 2 + m_lo[0]);
         check(phase, {q_hi_c, q_lo_c}, m_hi[1] * 2 + m_lo[1]);
      end
   end

   task automatic set_rst(input logic a, input logic b);
      rst_a = a;
      rst_b = b;
      if (a && b) model_clear();
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_lo(input int hi_c, input int lo_c);
      @(negedge clk); lo_in = 1'b1;
      wait_neg(hi_c);
      lo_in = 1'b0;
      wait_neg(lo_c);
   endtask

   task automatic pulse_hi(input int hi_c, input int lo_c);
      @(negedge clk); hi_drv = 1'b1;
      wait_neg(hi_c);
      hi_drv = 1'b0;
      wait_neg(lo_c);
   endtask

   task automatic settle(input int n);
      wait_neg(n);
      #3;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         checks++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic v;
      lo_in = 1'b0; hi_drv = 1'b0; ext_chain = 1'b0;
      set_rst(1'b1, 1'b1);
      settle(4);
      check("R7 reset state", {q_hi_a, q_lo_a}, 0);
      check("R7 reset state chain", {q_hi_c, q_lo_c}, 0);

      phase = "R8";
      @(negedge clk); set_rst(1'b0, 1'b0);
      settle(4);

      phase = "R1";
      pulse_lo(1, 1); pulse_lo(2, 3); pulse_lo(3, 1); pulse_lo(1, 2); pulse_lo(2, 2);
      settle(4);
      check("R1 five falls", q_lo_a, 1);

      phase = "R2";
      pulse_hi(1, 2); pulse_hi(2, 1); pulse_hi(1, 1);
      settle(4);
      check("R2 three falls", q_hi_a, 3);

      phase = "R4";
      pulse_lo(1, 1); pulse_lo(2, 2);
      settle(4);
      check("R4 hi unmoved by lo", q_hi_a, 3);
      check("R4 lo after two falls", q_lo_a, 1);

      phase = "R3";
      for (int i = 0; i < 7; i++) pulse_hi(1 + i % 2, 1 + i % 3);
      settle(4);
      check("R3 wrap to 2", q_hi_a, 2);

      phase = "R9";
      @(negedge clk); lo_in = 1'b1;
      settle(4);
      v = q_lo_a;
      @(negedge clk); lo_in = 1'b0;
      @(negedge clk); #3 check("R9 no change after edge k", q_lo_a, v);
      @(negedge clk); #3 check("R9 no change after edge k+1", q_lo_a, v);
      @(negedge clk); #3 check("R9 change at edge k+2", q_lo_a, !v);

      phase = "R5";
      v = q_lo_a;
      @(negedge clk); set_rst(1'b1, 1'b0);
      pulse_lo(1, 1);
      settle(4);
      check("R5 rst_a alone", q_lo_a, !v);
      @(negedge clk); set_rst(1'b0, 1'b1);
      pulse_hi(2, 1);
      settle(4);
      check("R5 rst_b alone", q_hi_a, 3);
      @(negedge clk); set_rst(1'b0, 1'b0);

      phase = "R6";
      @(negedge clk); set_rst(1'b1, 1'b1);
      #1;
      check("R6 immediate clear", {q_hi_a, q_lo_a}, 0);
      check("R6 immediate clear chain", {q_hi_c, q_lo_c}, 0);

      phase = "R7";
      pulse_lo(1, 1); pulse_hi(1, 1); pulse_lo(2, 1); pulse_hi(1, 2);
      settle(4);
      check("R7 inputs ignored in reset", {q_hi_a, q_lo_a}, 0);

      phase = "R8";
      @(negedge clk); lo_in = 1'b1;
      @(negedge clk); set_rst(1'b0, 1'b0);
      @(negedge clk); lo_in = 1'b0;
      settle(6);
      check("R8 early fall not counted", q_lo_a, 0);

      phase = "R11";
      @(negedge clk); set_rst(1'b1, 1'b1); ext_chain = 1'b1;
      settle(2);
      @(negedge clk); set_rst(1'b0, 1'b0);
      settle(4);
      for (int i = 0; i < 19; i++) begin
         @(negedge clk); hi_drv = ~hi_drv;   // ignored by both instances now
         pulse_lo(1 + i % 3, 4);
      end
      settle(8);
      check("R11 external chain mod 16", {q_hi_a, q_lo_a}, 19 % 16);
      check("R10 internal chain mod 16", {q_hi_c, q_lo_c}, 19 % 16);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule